// File: doc/BRIEF.md
# Address Error Trap Detector

This block screens every memory transaction a processor core issues and raises an address-error trap request when the transaction is illegal. Three kinds of transaction are checked. The first is a data-space access, which may be a byte or a word, and may run on the split X or Y bus of a dual-space (multiply-accumulate class) operation. The second is a data read or write that targets program memory. The third is an instruction fetch, which includes the literal target of a direct branch or jump.

The core presents one transaction per cycle, qualified by a valid strobe. The detector evaluates five fault conditions at once. When at least one of them holds, it emits a single-cycle trap request on the following clock, together with the code of the most urgent cause. All memory-map bounds are parameters, so one design serves any map size.

Top module: `addr_trap_detect`

## Requirements
- R1: A data access (`accKind` = 0) with `wordSize` = 1 and `dataAddr` bit 0 = 1 raises cause code 1 (misaligned). An odd byte access (`wordSize` = 0) does not raise it.
- R2: A data access with `dualSpace` = 0 and `dataAddr` above `DATA_HI` raises cause code 2 (unmapped data).
- R3: A data access with `dualSpace` = 1 raises cause code 2 when `dataAddr` lies outside the window of the selected bus: `X_LO`..`X_HI` when `ySel` = 0, and `Y_LO`..`Y_HI` when `ySel` = 1. The other bus's window therefore counts as unmapped.
- R4: A program-memory data access (`accKind` = 1) with `progAddr` above `PROG_HI` raises cause code 3.
- R5: An instruction fetch (`accKind` = 2) with `jumpTarget` = 0 and `progAddr` at or below `VEC_HI` raises cause code 4 (vector-space fetch). When `jumpTarget` = 1 the vector check does not apply.
- R6: An instruction fetch with `progAddr` above `PROG_HI` raises cause code 5. This holds whether the address is a jump literal (`jumpTarget` = 1) or was reached by other means.
- R7: When several causes hold for one transaction, `trapCause` reports the lowest cause code.
- R8: `trapReq` is high for exactly the one cycle after a clock edge that samples `accValid` = 1 with a fault. It stays low when `accValid` = 0, whatever the other inputs, and it stays low for `accKind` = 3 (idle).
- R9: `trapCause` is 0 whenever `trapReq` is low. Both outputs are 0 during and after reset (`rstN` low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Transaction strobe |
| accKind | input | 2 | 0 data, 1 program-memory data, 2 instruction fetch, 3 idle |
| dataAddr | input | DATA_AW | Data-space byte address |
| wordSize | input | 1 | 1 for a word access, 0 for a byte access |
| dualSpace | input | 1 | Dual-space (X/Y split) data access |
| ySel | input | 1 | Selects the Y bus during a dual-space access |
| progAddr | input | PROG_AW | Program-memory address |
| jumpTarget | input | 1 | `progAddr` is the literal target of a direct branch or jump |
| trapReq | output | 1 | Address-error trap request pulse |
| trapCause | output | 3 | Cause code 1 to 5, 0 when idle |

## Verification
The bench builds the detector with its default map. Data memory ends at 0x0FFF, the X window is 0x0800 to 0x0BFF and the Y window is 0x0C00 to 0x0FFF. Program memory ends at 0x1FFF and vector space ends at 0x7F. With this map every bound can be hit at the exact address on each side of it. The map also makes the misaligned and unmapped-data causes overlap, at an odd address past the top of data memory or an odd address in the wrong bus window, so the priority rule can be exercised.

// File: rtl/addr_trap_pkg.sv
package addr_trap_pkg;
  localparam int NUM_CAUSE = 5;
  localparam int CAUSE_W   = 3;

  typedef enum logic [1:0] {
    KIND_DATA     = 2'd0,
    KIND_PROGDATA = 2'd1,
    KIND_FETCH    = 2'd2,
    KIND_IDLE     = 2'd3
  } accKind_e;

  // Flag vector bit i corresponds to cause code i+1.
  typedef logic [NUM_CAUSE-1:0] faultVec_t;

  typedef struct packed {
    logic               fire;
    logic [CAUSE_W-1:0] cause;
  } ctrlStrobe_t;
endpackage

// File: rtl/addr_trap_dp.sv
module addr_trap_dp
  import addr_trap_pkg::*;
#(
  parameter int DATA_AW = 16,
  parameter int PROG_AW = 24,
  parameter logic [DATA_AW-1:0] DATA_HI = 16'h0FFF,
  parameter logic [DATA_AW-1:0] X_LO = 16'h0800,
  parameter logic [DATA_AW-1:0] X_HI = 16'h0BFF,
  parameter logic [DATA_AW-1:0] Y_LO = 16'h0C00,
  parameter logic [DATA_AW-1:0] Y_HI = 16'h0FFF,
  parameter logic [PROG_AW-1:0] PROG_HI = 24'h001FFF,
  parameter logic [PROG_AW-1:0] VEC_HI = 24'h00007F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         accKind,
  input  logic [DATA_AW-1:0] dataAddr,
  input  logic               wordSize,
  input  logic               dualSpace,
  input  logic               ySel,
  input  logic [PROG_AW-1:0] progAddr,
  input  logic               jumpTarget,
  input  ctrlStrobe_t        strobe,
  output faultVec_t          flags,
  output logic               trapReq,
  output logic [CAUSE_W-1:0] trapCause
);
  logic isData, isProgData, isFetch;
  logic inX, inY, dataMapped, progMapped;

  always_comb begin
    isData     = (accKind == KIND_DATA);
    isProgData = (accKind == KIND_PROGDATA);
    isFetch    = (accKind == KIND_FETCH);
    inX        = (dataAddr >= X_LO) && (dataAddr <= X_HI);
    inY        = (dataAddr >= Y_LO) && (dataAddr <= Y_HI);
    dataMapped = dualSpace ? (ySel ? inY : inX) : (dataAddr <= DATA_HI);
    progMapped = (progAddr <= PROG_HI);

    flags    = '0;
    flags[0] = isData && wordSize && dataAddr[0];
    flags[1] = isData && !dataMapped;
    flags[2] = isProgData && !progMapped;
    flags[3] = isFetch && !jumpTarget && (progAddr <= VEC_HI);
    flags[4] = isFetch && !progMapped;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapReq   <= 1'b0;
      trapCause <= '0;
    end else if (strobe.fire) begin
      trapReq   <= 1'b1;
      trapCause <= strobe.cause;
    end else begin
      trapReq   <= 1'b0;
      trapCause <= '0;
    end
  end
endmodule

// File: rtl/addr_trap_ctl.sv
module addr_trap_ctl
  import addr_trap_pkg::*;
(
  input  logic        accValid,
  input  faultVec_t   flags,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.fire  = accValid && (|flags);
    strobe.cause = '0;
    // Scan from the highest code down so the lowest set code wins.
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (flags[i]) strobe.cause = CAUSE_W'(i + 1);
    end
  end
endmodule

// File: rtl/addr_trap_detect.sv
module addr_trap_detect
  import addr_trap_pkg::*;
#(
  parameter int DATA_AW = 16,
  parameter int PROG_AW = 24,
  parameter logic [DATA_AW-1:0] DATA_HI = 16'h0FFF,
  parameter logic [DATA_AW-1:0] X_LO = 16'h0800,
  parameter logic [DATA_AW-1:0] X_HI = 16'h0BFF,
  parameter logic [DATA_AW-1:0] Y_LO = 16'h0C00,
  parameter logic [DATA_AW-1:0] Y_HI = 16'h0FFF,
  parameter logic [PROG_AW-1:0] PROG_HI = 24'h001FFF,
  parameter logic [PROG_AW-1:0] VEC_HI = 24'h00007F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [1:0]         accKind,
  input  logic [DATA_AW-1:0] dataAddr,
  input  logic               wordSize,
  input  logic               dualSpace,
  input  logic               ySel,
  input  logic [PROG_AW-1:0] progAddr,
  input  logic               jumpTarget,
  output logic               trapReq,
  output logic [2:0]         trapCause
);
  faultVec_t   flags;
  ctrlStrobe_t strobe;

  addr_trap_dp #(
    .DATA_AW(DATA_AW), .PROG_AW(PROG_AW), .DATA_HI(DATA_HI),
    .X_LO(X_LO), .X_HI(X_HI), .Y_LO(Y_LO), .Y_HI(Y_HI),
    .PROG_HI(PROG_HI), .VEC_HI(VEC_HI)
  ) dp_i (
    .clk(clk), .rstN(rstN), .accKind(accKind), .dataAddr(dataAddr),
    .wordSize(wordSize), .dualSpace(dualSpace), .ySel(ySel),
    .progAddr(progAddr), .jumpTarget(jumpTarget), .strobe(strobe),
    .flags(flags), .trapReq(trapReq), .trapCause(trapCause)
  );

  addr_trap_ctl ctl_i (
    .accValid(accValid), .flags(flags), .strobe(strobe)
  );
endmodule

// File: rtl/addr_trap_chk.sv
module addr_trap_chk #(
  parameter int DATA_AW = 16,
  parameter int PROG_AW = 24,
  parameter logic [DATA_AW-1:0] DATA_HI = 16'h0FFF,
  parameter logic [PROG_AW-1:0] PROG_HI = 24'h001FFF,
  parameter logic [PROG_AW-1:0] VEC_HI = 24'h00007F
) (
  input logic               clk,
  input logic               rstN,
  input logic               accValid,
  input logic [1:0]         accKind,
  input logic [DATA_AW-1:0] dataAddr,
  input logic               wordSize,
  input logic               dualSpace,
  input logic               ySel,
  input logic [PROG_AW-1:0] progAddr,
  input logic               jumpTarget,
  input logic               trapReq,
  input logic [2:0]         trapCause
);
  // R1
  misalign_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == 2'd0 && wordSize && dataAddr[0])
      |=> (trapReq && trapCause == 3'd1));

  // R2
  flat_unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == 2'd0 && !dualSpace && !dataAddr[0] && dataAddr > DATA_HI)
      |=> (trapReq && trapCause == 3'd2));

  // R4
  prog_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == 2'd1 && progAddr > PROG_HI)
      |=> (trapReq && trapCause == 3'd3));

  // R5
  vector_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == 2'd2 && !jumpTarget && progAddr <= VEC_HI)
      |=> (trapReq && trapCause == 3'd4));

  // R6
  prog_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == 2'd2 && progAddr > PROG_HI && progAddr > VEC_HI)
      |=> (trapReq && trapCause == 3'd5));

  // R8
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid || accKind == 2'd3) |=> !trapReq);

  // R9
  cause_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |-> (trapCause == 3'd0));

  // R9
  cause_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (trapCause >= 3'd1 && trapCause <= 3'd5));

  // R8
  source_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trapReq) |-> $past(accValid));

  // R2 unused here: ySel feeds R3, which the bench covers.
  logic unusedSel;
  assign unusedSel = ySel;
endmodule

bind addr_trap_detect addr_trap_chk #(
  .DATA_AW(DATA_AW), .PROG_AW(PROG_AW), .DATA_HI(DATA_HI),
  .PROG_HI(PROG_HI), .VEC_HI(VEC_HI)
) chk_i (.*);

// File: tb/addr_trap_detect_tb.sv
module addr_trap_detect_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid;
  logic [1:0]  accKind;
  logic [15:0] dataAddr;
  logic        wordSize;
  logic        dualSpace;
  logic        ySel;
  logic [23:0] progAddr;
  logic        jumpTarget;
  logic        trapReq;
  logic [2:0]  trapCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_trap_detect dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accKind(accKind),
    .dataAddr(dataAddr), .wordSize(wordSize), .dualSpace(dualSpace),
    .ySel(ySel), .progAddr(progAddr), .jumpTarget(jumpTarget),
    .trapReq(trapReq), .trapCause(trapCause)
  );

  task automatic check(string req, logic expReq, logic [2:0] expCause);
    checks++;
    if (trapReq !== expReq || trapCause !== expCause) begin
      errors++;
      $display("FAIL %s: req=%0b cause=%0d expected req=%0b cause=%0d",
               req, trapReq, trapCause, expReq, expCause);
    end
  endtask

  // Drive one transaction, check the result one edge later and the
  // return to quiet one edge after that (R8).
  task automatic access(string req, logic valid, logic [1:0] kind,
                        logic [15:0] dAddr, logic word, logic dual,
                        logic ys, logic [23:0] pAddr, logic jmp,
                        logic expReq, logic [2:0] expCause);
    @(negedge clk);
    accValid = valid; accKind = kind; dataAddr = dAddr; wordSize = word;
    dualSpace = dual; ySel = ys; progAddr = pAddr; jumpTarget = jmp;
    @(negedge clk);
    accValid = 1'b0;
    check(req, expReq, expCause);
    @(negedge clk);
    check({req, " R8 pulse end"}, 1'b0, 3'd0);
  endtask

  task automatic test_reset();
    rstN = 1'b0; accValid = 1'b1; accKind = 2'd0; dataAddr = 16'hFFFF;
    wordSize = 1'b1; dualSpace = 1'b0; ySel = 1'b0; progAddr = 24'hFFFFFF;
    jumpTarget = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 3'd0);
    accValid = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic test_misalign();
    access("R1 odd word", 1, 2'd0, 16'h0801, 1, 0, 0, 0, 0, 1, 3'd1);
    access("R1 odd byte", 1, 2'd0, 16'h0801, 0, 0, 0, 0, 0, 0, 3'd0);
    access("R1 even word", 1, 2'd0, 16'h0800, 1, 0, 0, 0, 0, 0, 3'd0);
  endtask

  task automatic test_flat_data();
    access("R2 above top", 1, 2'd0, 16'h1000, 1, 0, 0, 0, 0, 1, 3'd2);
    access("R2 at top", 1, 2'd0, 16'h0FFE, 1, 0, 0, 0, 0, 0, 3'd0);
    access("R2 top byte", 1, 2'd0, 16'h0FFF, 0, 0, 0, 0, 0, 0, 3'd0);
  endtask

  task automatic test_dual();
    access("R3 X bus in Y", 1, 2'd0, 16'h0C00, 1, 1, 0, 0, 0, 1, 3'd2);
    access("R3 X bus ok", 1, 2'd0, 16'h0BFE, 1, 1, 0, 0, 0, 0, 3'd0);
    access("R3 X bus low", 1, 2'd0, 16'h07FE, 1, 1, 0, 0, 0, 1, 3'd2);
    access("R3 Y bus in X", 1, 2'd0, 16'h0BFE, 1, 1, 1, 0, 0, 1, 3'd2);
    access("R3 Y bus ok", 1, 2'd0, 16'h0C00, 1, 1, 1, 0, 0, 0, 3'd0);
  endtask

  task automatic test_prog_data();
    access("R4 beyond", 1, 2'd1, 16'h0, 1, 0, 0, 24'h002000, 0, 1, 3'd3);
    access("R4 last", 1, 2'd1, 16'h0, 1, 0, 0, 24'h001FFE, 0, 0, 3'd0);
  endtask

  task automatic test_fetch();
    access("R5 vector", 1, 2'd2, 16'h0, 0, 0, 0, 24'h000040, 0, 1, 3'd4);
    access("R5 vec edge", 1, 2'd2, 16'h0, 0, 0, 0, 24'h00007F, 0, 1, 3'd4);
    access("R5 past vec", 1, 2'd2, 16'h0, 0, 0, 0, 24'h000080, 0, 0, 3'd0);
    access("R5 jump vec", 1, 2'd2, 16'h0, 0, 0, 0, 24'h000040, 1, 0, 3'd0);
    access("R6 fetch out", 1, 2'd2, 16'h0, 0, 0, 0, 24'h002000, 0, 1, 3'd5);
    access("R6 jump out", 1, 2'd2, 16'h0, 0, 0, 0, 24'h002000, 1, 1, 3'd5);
    access("R6 fetch last", 1, 2'd2, 16'h0, 0, 0, 0, 24'h001FFE, 1, 0, 3'd0);
  endtask

  task automatic test_priority();
    access("R7 odd high", 1, 2'd0, 16'h1001, 1, 0, 0, 0, 0, 1, 3'd1);
    access("R7 odd wrong bus", 1, 2'd0, 16'h0801, 1, 1, 1, 0, 0, 1, 3'd1);
  endtask

  task automatic test_quiet();
    access("R8 not valid", 0, 2'd0, 16'hFFFF, 1, 0, 0, 24'hFFFFFF, 0, 0, 3'd0);
    access("R8 idle kind", 1, 2'd3, 16'hFFFF, 1, 0, 0, 24'hFFFFFF, 0, 0, 3'd0);
    // Back-to-back faults: second cause must follow the first directly.
    @(negedge clk);
    accValid = 1; accKind = 2'd1; progAddr = 24'h003000;
    @(negedge clk);
    check("R8 b2b first", 1'b1, 3'd3);
    accKind = 2'd2; progAddr = 24'h000010; jumpTarget = 1'b0;
    @(negedge clk);
    accValid = 1'b0;
    check("R8 b2b second", 1'b1, 3'd4);
    @(negedge clk);
    check("R9 after b2b", 1'b0, 3'd0);
  endtask

  initial begin
    test_reset();
    test_misalign();
    test_flat_data();
    test_dual();
    test_prog_data();
    test_fetch();
    test_priority();
    test_quiet();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule